// File: doc/BRIEF.md
# Synthesizer Divider Chain with Test-Output Selector

This block holds the two programmable dividers of a frequency synthesizer. One is the feedback divider, which divides by a 7-bit value M. The other is the output divider, which divides by a power of two picked with a 2-bit code. A single debug pin sits beside them. A 3-bit select routes one of eight internal nodes to that pin: fixed levels, the reference clock, the serial shift-register output, the output clock, or divided copies of the two dividers. The phase detector and the oscillator are outside the block. The oscillator is represented by a clock input that drives both dividers.

One select value puts the block in bypass. The slow serial clock then replaces the oscillator clock as the source for both dividers. The output divider drives the main output. The feedback divider, halved, drives the debug pin. A board can then step the clock tree one edge at a time from the serial clock.

Top module: `divchain_top`

## Requirements
- R1: With test select 3'b000, `test_o` equals `shift_out_i`.
- R2: Test select 3'b001 drives `test_o` high, and 3'b101 drives it low. Both hold whatever `shift_out_i` and `ref_clk_i` do.
- R3: With test select 3'b010, `test_o` equals `ref_clk_i`.
- R4: The output-divider code on `n_sel_i` maps to a divide ratio as follows: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8. With code 2'b00, `fout_o` follows the divider clock itself, so it is high while that clock is high.
- R5: With test select 3'b011, `test_o` is the feedback divider output halved, with a period of 2*M divider-clock cycles. M values 0 and 1 both behave as 1. The feedback divider pulse itself is one cycle wide and is not a 50% duty-cycle signal.
- R6: Test select 3'b100 puts `fout_o` on `test_o`. Test select 3'b111 puts `fout_o` divided by 4 on `test_o`.
- R7: Test select 3'b110 selects bypass. `ser_clk_i` then clocks both dividers, `fout_o` is `ser_clk_i` divided by the N ratio, and `test_o` is the halved feedback divider. In this mode, edges of `vco_clk_i` have no effect on either output.
- R8: The synchronous active-high reset `rst_i` clears both dividers. While it is held, `fout_o` and every divider-derived node on `test_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk_i | input | 1 | Oscillator clock that feeds the dividers in normal mode |
| ref_clk_i | input | 1 | Reference clock, observable on the debug pin |
| ser_clk_i | input | 1 | Serial clock that feeds the dividers in bypass |
| rst_i | input | 1 | Synchronous active-high reset on the divider clock |
| shift_out_i | input | 1 | Serial shift-register output, observable on the debug pin |
| m_val_i | input | 7 | Feedback divide value M |
| n_sel_i | input | 2 | Output divide code |
| t_sel_i | input | 3 | Debug pin select; 3'b110 selects bypass |
| fout_o | output | 1 | Divided output clock |
| test_o | output | 1 | Debug pin |

## Verification
The hardest case to reach is bypass, because a clock the bench must pulse by hand replaces the divider clock. The bench stops the oscillator's influence by switching the select to 3'b110. It then toggles the serial clock itself and counts rising edges of both outputs over a window of whole periods. The window is sampled once in each clock phase, so a divide-by-1 output that follows the clock is counted as well. A separate window holds the serial clock still while the oscillator keeps running, and it must show no output edges.

// File: rtl/divchain_pkg.sv
package divchain_pkg;

    localparam int M_W_DEF = 7;
    localparam int N_W_DEF = 2;

    typedef enum logic [2:0] {
        TS_SHIFT  = 3'b000,
        TS_HIGH   = 3'b001,
        TS_REF    = 3'b010,
        TS_MHALF  = 3'b011,
        TS_FOUT   = 3'b100,
        TS_LOW    = 3'b101,
        TS_BYPASS = 3'b110,
        TS_FOUT_Q = 3'b111
    } tsel_e;

    typedef struct packed {
        logic fout;
        logic fout_q;
        logic m_half;
    } taps_t;

    function automatic logic is_bypass(input logic [2:0] sel);
        return sel == TS_BYPASS;
    endfunction

endpackage

// File: rtl/m_divider.sv
module m_divider #(
    parameter int M_W = divchain_pkg::M_W_DEF
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [M_W-1:0] m_val_i,
    output logic           pulse_o,
    output logic           half_o
);
    logic [M_W-1:0] cnt_q;
    logic           pulse_q;
    logic           half_q;
    logic           term;

    assign term = (cnt_q <= M_W'(1));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (term) begin
            cnt_q   <= m_val_i;
            pulse_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_q - 1'b1;
            pulse_q <= 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            half_q <= 1'b0;
        end else if (pulse_q) begin
            half_q <= ~half_q;
        end
    end

    assign pulse_o = pulse_q;
    assign half_o  = half_q;

    AST_MPULSE_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_q >= M_W'(2)) |=> !pulse_q); // R5
    AST_MHALF_FLIP: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_q |=> (half_q != $past(half_q))); // R5
    AST_MHALF_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !pulse_q |=> $stable(half_q)); // R5

endmodule

// File: rtl/n_divider.sv
module n_divider #(
    parameter int N_W = divchain_pkg::N_W_DEF
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [N_W-1:0] n_sel_i,
    output logic           fout_o,
    output logic           fout_q_o
);
    localparam int NRAT = 2 ** N_W;
    localparam int CW   = NRAT + 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        fout_o   = 1'b0;
        fout_q_o = 1'b0;
        for (int k = 0; k < NRAT; k++) begin
            if (n_sel_i == N_W'(k)) begin
                if (k == 0) begin
                    fout_o = clk_i & ~rst_i;
                end else begin
                    fout_o = cnt_q[(k == 0) ? 0 : k - 1];
                end
                fout_q_o = cnt_q[k + 1];
            end
        end
    end

    AST_NCNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (cnt_q == CW'($past(cnt_q) + 1'b1))); // R4
    AST_NCNT_RST: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (cnt_q == '0)); // R8

endmodule

// File: rtl/test_mux.sv
module test_mux
    import divchain_pkg::*;
(
    input  logic [2:0] t_sel_i,
    input  logic       shift_out_i,
    input  logic       ref_clk_i,
    input  taps_t      taps_i,
    output logic       test_o
);
    tsel_e sel;

    assign sel = tsel_e'(t_sel_i);

    always_comb begin
        unique case (sel)
            TS_SHIFT:  test_o = shift_out_i;
            TS_HIGH:   test_o = 1'b1;
            TS_REF:    test_o = ref_clk_i;
            TS_MHALF:  test_o = taps_i.m_half;
            TS_FOUT:   test_o = taps_i.fout;
            TS_LOW:    test_o = 1'b0;
            TS_BYPASS: test_o = taps_i.m_half;
            TS_FOUT_Q: test_o = taps_i.fout_q;
            default:   test_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/divchain_top.sv
module divchain_top
    import divchain_pkg::*;
#(
    parameter int M_W = M_W_DEF,
    parameter int N_W = N_W_DEF
) (
    input  logic           vco_clk_i,
    input  logic           ref_clk_i,
    input  logic           ser_clk_i,
    input  logic           rst_i,
    input  logic           shift_out_i,
    input  logic [M_W-1:0] m_val_i,
    input  logic [N_W-1:0] n_sel_i,
    input  logic [2:0]     t_sel_i,
    output logic           fout_o,
    output logic           test_o
);
    logic  div_clk;
    logic  m_pulse;
    taps_t taps;

    assign div_clk = is_bypass(t_sel_i) ? ser_clk_i : vco_clk_i;

    m_divider #(.M_W(M_W)) u_mdiv (
        .clk_i   (div_clk),
        .rst_i   (rst_i),
        .m_val_i (m_val_i),
        .pulse_o (m_pulse),
        .half_o  (taps.m_half)
    );

    n_divider #(.N_W(N_W)) u_ndiv (
        .clk_i    (div_clk),
        .rst_i    (rst_i),
        .n_sel_i  (n_sel_i),
        .fout_o   (taps.fout),
        .fout_q_o (taps.fout_q)
    );

    test_mux u_tmux (
        .t_sel_i     (t_sel_i),
        .shift_out_i (shift_out_i),
        .ref_clk_i   (ref_clk_i),
        .taps_i      (taps),
        .test_o      (test_o)
    );

    assign fout_o = taps.fout;

    AST_MPULSE_HALF: assert property (@(posedge div_clk) disable iff (rst_i)
        (m_pulse && !$past(m_pulse)) |=> (taps.m_half != $past(taps.m_half))); // R5

endmodule

// File: tb/tb_divchain_top.sv
module tb_divchain_top;

    logic       vco_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       ser_clk = 1'b0;
    logic       rst = 1'b1;
    logic       shift_out = 1'b0;
    logic [6:0] m_val = 7'd4;
    logic [1:0] n_sel = 2'b00;
    logic [2:0] t_sel = 3'b000;
    logic       fout;
    logic       test;

    int n_checks = 0;
    int n_fail = 0;

    always #2 vco_clk = ~vco_clk;

    divchain_top dut (
        .vco_clk_i   (vco_clk),
        .ref_clk_i   (ref_clk),
        .ser_clk_i   (ser_clk),
        .rst_i       (rst),
        .shift_out_i (shift_out),
        .m_val_i     (m_val),
        .n_sel_i     (n_sel),
        .t_sel_i     (t_sel),
        .fout_o      (fout),
        .test_o      (test)
    );

    // {t_sel, shift_out, ref_clk, expected test}
    localparam logic [5:0] VEC [8] = '{
        {3'b000, 1'b1, 1'b0, 1'b1},   // R1
        {3'b000, 1'b0, 1'b1, 1'b0},   // R1
        {3'b001, 1'b0, 1'b0, 1'b1},   // R2
        {3'b001, 1'b1, 1'b1, 1'b1},   // R2
        {3'b101, 1'b1, 1'b1, 1'b0},   // R2
        {3'b101, 1'b0, 1'b0, 1'b0},   // R2
        {3'b010, 1'b0, 1'b1, 1'b1},   // R3
        {3'b010, 1'b1, 1'b0, 1'b0}    // R3
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // count rising edges of fout/test over 'cyc' oscillator cycles, sampled in both phases
    task automatic meas_vco(input int cyc, output int ef, output int et);
        logic pf, pt;
        ef = 0;
        et = 0;
        @(posedge vco_clk);
        #1;
        pf = fout;
        pt = test;
        for (int i = 0; i < 2 * cyc; i++) begin
            #2;
            if (fout && !pf) ef++;
            if (test && !pt) et++;
            pf = fout;
            pt = test;
        end
    endtask

    task automatic meas_ser(input int cyc, output int ef, output int et);
        logic pf, pt;
        ef = 0;
        et = 0;
        ser_clk = 1'b1;
        #1;
        pf = fout;
        pt = test;
        for (int i = 0; i < cyc; i++) begin
            #4 ser_clk = 1'b0;
            #1;
            if (fout && !pf) ef++;
            if (test && !pt) et++;
            pf = fout;
            pt = test;
            #4 ser_clk = 1'b1;
            #1;
            if (fout && !pf) ef++;
            if (test && !pt) et++;
            pf = fout;
            pt = test;
        end
        #4 ser_clk = 1'b0;
    endtask

    task automatic settle_vco();
        repeat (24) @(posedge vco_clk);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int ef, et;

        // R8: reset state
        n_sel = 2'b00;
        t_sel = 3'b011;
        repeat (6) @(posedge vco_clk);
        #1;
        chk("R8 fout high phase in reset", fout, 0);
        chk("R8 m_half in reset", test, 0);
        t_sel = 3'b111;
        #2;
        chk("R8 fout/4 in reset", test, 0);
        meas_vco(8, ef, et);
        chk("R8 fout edges in reset", ef, 0);
        @(negedge vco_clk);
        rst = 1'b0;

        // R1 R2 R3: static selects
        foreach (VEC[i]) begin
            t_sel = VEC[i][5:3];
            shift_out = VEC[i][2];
            ref_clk = VEC[i][1];
            #1;
            chk("R1/R2/R3 static select", test, VEC[i][0]);
        end

        // R4: divide ratios, R6: fout and fout/4 on test
        n_sel = 2'b00; t_sel = 3'b111; settle_vco();
        meas_vco(64, ef, et);
        chk("R4 ratio 1 fout", ef, 64);
        chk("R6 fout/4 at ratio 1", et, 16);
        n_sel = 2'b01; t_sel = 3'b100; settle_vco();
        meas_vco(64, ef, et);
        chk("R4 ratio 2 fout", ef, 32);
        chk("R6 fout on test", et, 32);
        n_sel = 2'b10; settle_vco();
        meas_vco(64, ef, et);
        chk("R4 ratio 4 fout", ef, 16);
        n_sel = 2'b11; t_sel = 3'b111; settle_vco();
        meas_vco(64, ef, et);
        chk("R4 ratio 8 fout", ef, 8);
        chk("R6 fout/4 at ratio 8", et, 2);

        // R5: feedback divider halved
        t_sel = 3'b011;
        m_val = 7'd4; settle_vco();
        meas_vco(64, ef, et);
        chk("R5 M=4", et, 8);
        m_val = 7'd8; settle_vco();
        meas_vco(64, ef, et);
        chk("R5 M=8", et, 4);
        m_val = 7'd1; settle_vco();
        meas_vco(64, ef, et);
        chk("R5 M=1", et, 32);
        m_val = 7'd0; settle_vco();
        meas_vco(64, ef, et);
        chk("R5 M=0 acts as 1", et, 32);

        // R7: bypass
        n_sel = 2'b00; m_val = 7'd3;
        @(posedge vco_clk); #1;
        t_sel = 3'b110;
        meas_ser(16, ef, et);
        meas_ser(24, ef, et);
        chk("R7 bypass ratio 1 fout", ef, 24);
        chk("R7 bypass M=3 test", et, 4);
        n_sel = 2'b10; m_val = 7'd6;
        meas_ser(16, ef, et);
        meas_ser(24, ef, et);
        chk("R7 bypass ratio 4 fout", ef, 6);
        chk("R7 bypass M=6 test", et, 2);
        n_sel = 2'b01;
        meas_vco(20, ef, et);
        chk("R7 oscillator ignored fout", ef, 0);
        chk("R7 oscillator ignored test", et, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule